// File: doc/BRIEF.md
# Byte-Paced I2C Master Controller

This block is an I2C bus master that software drives one byte at a time through four small registers: control, status, data and a stored own-address byte. Software loads the data register and writes a mode with the start bit set. The controller then puts a START on the bus and sends that byte as the address. After every byte it raises a pending flag and holds SCL low until software clears the flag. While the bus is held, software decides what comes next: another data byte, a repeated START with a new direction, or a STOP.

The bus clock comes from the system clock. It is divided by one of two prescaler values and then by a 4-bit divisor plus one. Each SCL period is split into four equal phases. SDA is changed only in the phase where SCL is low, except during START and STOP. In receive mode the controller drives the acknowledge slot itself. A control bit selects ACK or NACK, so software clears that bit before the last byte to end a read. On transmit, the controller records the slave's acknowledge. If it finds SDA pulled low while it was releasing SDA, it reports a lost bus and lets go of both lines.

The bus is modelled as two drive-low outputs plus the sensed SDA level. SCL is never stretched by a slave.

Top module: `i2cm_byte_master`

## Requirements
- R1: After reset the control, status and data registers read 0x00, both drive-low outputs are 0 and `irq` is 0.
- R2: One SCL period lasts P*(D+1) clock cycles. D is control bits 3:0. P is parameter PRE_LO when control bit 6 is 0 and PRE_HI when it is 1.
- R3: A status write with bits 7, 5 and 4 all set while the bus is idle starts a transfer. The controller issues a START (SDA falls while SCL is high) and then sends the data register MSB first. Status bit 5 reads 1 from then until the STOP completes.
- R4: After the ninth SCL pulse of every byte, control bit 4 (pending) becomes 1. SCL stays driven low until software writes the control register with bit 4 at 0. The next byte then uses the data register as it is at that moment.
- R5: Status bit 0 reads 1 when the slave left SDA high in the acknowledge slot of the last transmitted byte, and 0 when the slave pulled it low.
- R6: A status write with bit 5 set while the bus is busy makes the controller issue a repeated START on the next release and send the data register as the address. With status bits 7:6 = 10, the bytes that follow are received.
- R7: A status write with bit 5 clear while the bus is busy makes the controller issue a STOP (SDA rises while SCL is high) on the next release. Status bit 5 then returns to 0 with both lines released.
- R8: In receive mode the received byte is in the data register when pending rises. The controller pulls the acknowledge slot low when control bit 7 is 1 and leaves it high (NACK) when that bit is 0.
- R9: If SDA reads low while the controller is releasing it for a data bit of a transmitted byte, the following all happen. Status bit 3 becomes 1. Both lines are released. Status bit 5 reads 0. Pending becomes 1.
- R10: `irq` is 1 exactly when pending is 1 and control bit 5 is 1.
- R11: A status write with bit 4 at 0 does not start a transfer, even with bits 7 and 5 set.
- R12: While a byte is being shifted, SDA changes only while SCL is low. The only SDA edges with SCL high are the intended START and STOP conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data, 3 own address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Sensed SDA level |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the controller with PRE_LO = 4 and PRE_HI = 8. With those values a single bit lasts at most 128 cycles. The bench therefore sweeps all 32 combinations of prescaler choice and divisor, and checks the measured SCL period and the address byte seen by a modelled slave for every one. The same small values keep the full scenarios short enough to run in the same test: multi-byte writes, a random-address read through a repeated START with its final NACK, a refused acknowledge, and a forced low on SDA.

// File: rtl/i2cm_pkg.sv
// Package: shared register offsets and engine state encoding for the
// byte-paced I2C master. Assumes a 2-bit register select.
package i2cm_pkg;
    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_STAT = 2'd1;
    localparam logic [1:0] RA_DATA = 2'd2;
    localparam logic [1:0] RA_OWN  = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_SHIFT,
        ST_HOLD,
        ST_STOP
    } eng_st_t;
endpackage

// File: rtl/i2cm_qtick.sv
// Quarter-phase tick generator. One SCL period is four ticks, so a tick
// comes every (PRE/4)*(div+1) cycles. Assumes PRE_LO and PRE_HI are
// multiples of 4. The counter stays at zero while run is low.
module i2cm_qtick #(
    parameter int PRE_LO = 16,
    parameter int PRE_HI = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       pre_sel,
    input  logic [3:0] div,
    output logic       tick
);
    localparam int Q_LO = PRE_LO / 4;
    localparam int Q_HI = PRE_HI / 4;
    localparam int CW   = $clog2(Q_HI * 16 + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim  = (pre_sel ? CW'(Q_HI) : CW'(Q_LO)) * (CW'(div) + CW'(1));
    assign tick = run && (cnt >= lim - CW'(1));

    // Count cycles within one quarter phase and wrap on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (cnt >= lim - CW'(1)) cnt <= '0;
        else cnt <= cnt + CW'(1);
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $stable(lim)) |-> (cnt < lim));
endmodule

// File: rtl/i2cm_engine.sv
// Bit engine: produces START, repeated START, STOP and 9-bit byte frames
// (8 data bits plus acknowledge) on quarter-phase ticks. SCL is left low
// in HOLD until resume. Assumes tick is only produced while run is high.
module i2cm_engine
    import i2cm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       go_start,
    input  logic       resume,
    input  logic       req_rs,
    input  logic       req_stop,
    input  logic       rx_mode,
    input  logic       ack_en,
    input  logic [7:0] tx_byte,
    input  logic       sda_in,
    output logic       run,
    output logic       busy,
    output logic       scl_low,
    output logic       sda_low,
    output logic       byte_done,
    output logic       rx_upd,
    output logic [7:0] rx_byte,
    output logic       nack_upd,
    output logic       nack_val,
    output logic       lost
);
    eng_st_t    st;
    logic [1:0] q;
    logic [3:0] bitn;
    logic [7:0] sh;
    logic       tx;

    assign run     = (st == ST_START) || (st == ST_SHIFT) || (st == ST_STOP);
    assign busy    = (st != ST_IDLE);
    assign rx_byte = sh;

    // Sequence bus conditions and shift bits, one action per quarter tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; q <= 2'd0; bitn <= 4'd0; sh <= 8'd0; tx <= 1'b1;
            scl_low <= 1'b0; sda_low <= 1'b0; byte_done <= 1'b0;
            rx_upd <= 1'b0; nack_upd <= 1'b0; nack_val <= 1'b0; lost <= 1'b0;
        end else begin
            byte_done <= 1'b0; rx_upd <= 1'b0; nack_upd <= 1'b0; lost <= 1'b0;
            case (st)
                ST_IDLE: if (go_start) begin st <= ST_START; q <= 2'd0; end
                ST_HOLD: if (resume) begin
                    q <= 2'd0;
                    if (req_rs) st <= ST_START;
                    else if (req_stop) st <= ST_STOP;
                    else begin
                        st <= ST_SHIFT; bitn <= 4'd0; sh <= tx_byte; tx <= !rx_mode;
                    end
                end
                default: if (tick) begin
                    q <= q + 2'd1;
                    if (st == ST_START) begin
                        case (q)
                            2'd0: sda_low <= 1'b0;
                            2'd1: scl_low <= 1'b0;
                            2'd2: sda_low <= 1'b1;
                            default: begin
                                scl_low <= 1'b1; st <= ST_SHIFT;
                                bitn <= 4'd0; sh <= tx_byte; tx <= 1'b1;
                            end
                        endcase
                    end else if (st == ST_SHIFT) begin
                        case (q)
                            2'd0: sda_low <= (bitn == 4'd8) ? (!tx && ack_en) : (tx && !sh[7]);
                            2'd1: scl_low <= 1'b0;
                            2'd2: begin
                                if (bitn == 4'd8) begin
                                    if (tx) begin nack_upd <= 1'b1; nack_val <= sda_in; end
                                end else if (tx && !sda_low && !sda_in) begin
                                    lost <= 1'b1; st <= ST_IDLE; q <= 2'd0;
                                    scl_low <= 1'b0; sda_low <= 1'b0;
                                end else sh <= {sh[6:0], sda_in};
                            end
                            default: begin
                                scl_low <= 1'b1;
                                if (bitn == 4'd8) begin
                                    st <= ST_HOLD; byte_done <= 1'b1; rx_upd <= !tx;
                                end else bitn <= bitn + 4'd1;
                            end
                        endcase
                    end else begin
                        case (q)
                            2'd0: sda_low <= 1'b1;
                            2'd1: scl_low <= 1'b0;
                            2'd2: sda_low <= 1'b0;
                            default: st <= ST_IDLE;
                        endcase
                    end
                end
            endcase
        end
    end

    // R12
    sda_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SHIFT && $past(st == ST_SHIFT) && !scl_low && $past(!scl_low))
        |-> $stable(sda_low));
endmodule

// File: rtl/i2cm_byte_master.sv
// Top: register file and pacing logic for the byte-paced I2C master.
// Holds the control, status, data and own-address registers. Sets pending
// after each byte and releases the engine when software clears it.
// Assumes an external pull-up: a line reads high unless some party pulls it low.
module i2cm_byte_master
    import i2cm_pkg::*;
#(
    parameter int PRE_LO = 16,
    parameter int PRE_HI = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       scl_drive_low,
    output logic       sda_drive_low,
    input  logic       sda_in,
    output logic       irq
);
    logic       ack_en, pre_sel, ie, pend;
    logic [3:0] div;
    logic [1:0] mode;
    logic       txen, lost_f, nack_f, req_rs, req_stop;
    logic [7:0] data_q, own_q;
    logic       tick, run, busy, byte_done, rx_upd, nack_upd, nack_val, lost;
    logic [7:0] rx_byte;
    logic       wr_ctrl, wr_stat, go_start, resume;

    assign wr_ctrl  = reg_we && (reg_addr == RA_CTRL);
    assign wr_stat  = reg_we && (reg_addr == RA_STAT);
    assign go_start = wr_stat && reg_wdata[7] && reg_wdata[5] && reg_wdata[4] && !busy;
    assign resume   = wr_ctrl && !reg_wdata[4] && pend;
    assign irq      = pend && ie;

    i2cm_qtick #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .pre_sel(pre_sel), .div(div), .tick(tick)
    );

    i2cm_engine u_eng (
        .clk(clk), .rst_n(rst_n), .tick(tick), .go_start(go_start), .resume(resume),
        .req_rs(req_rs), .req_stop(req_stop), .rx_mode(mode == 2'b10),
        .ack_en(ack_en), .tx_byte(data_q), .sda_in(sda_in), .run(run), .busy(busy),
        .scl_low(scl_drive_low), .sda_low(sda_drive_low), .byte_done(byte_done),
        .rx_upd(rx_upd), .rx_byte(rx_byte), .nack_upd(nack_upd), .nack_val(nack_val),
        .lost(lost)
    );

    // Control register and pending flag: software clears pending, bytes set it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_en <= 1'b0; pre_sel <= 1'b0; ie <= 1'b0; pend <= 1'b0; div <= 4'd0;
        end else begin
            if (wr_ctrl) begin
                ack_en <= reg_wdata[7]; pre_sel <= reg_wdata[6];
                ie <= reg_wdata[5]; div <= reg_wdata[3:0];
                if (!reg_wdata[4]) pend <= 1'b0;
            end
            if (go_start) pend <= 1'b0;
            if (byte_done || lost) pend <= 1'b1;
        end
    end

    // Status register: mode, enable, queued bus command and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= 2'b00; txen <= 1'b0; req_rs <= 1'b0; req_stop <= 1'b0;
            lost_f <= 1'b0; nack_f <= 1'b0;
        end else begin
            if (wr_stat) begin
                mode <= reg_wdata[7:6]; txen <= reg_wdata[4];
                if (busy) begin
                    if (reg_wdata[5]) req_rs <= 1'b1;
                    else req_stop <= 1'b1;
                end
            end
            if (resume || go_start) begin req_rs <= 1'b0; req_stop <= 1'b0; end
            if (go_start) lost_f <= 1'b0;
            if (lost) lost_f <= 1'b1;
            if (nack_upd) nack_f <= nack_val;
        end
    end

    // Data and own-address registers; received bytes overwrite the data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= 8'd0; own_q <= 8'd0;
        end else begin
            if (reg_we && reg_addr == RA_DATA) data_q <= reg_wdata;
            else if (rx_upd) data_q <= rx_byte;
            if (reg_we && reg_addr == RA_OWN) own_q <= reg_wdata;
        end
    end

    // Read multiplexer over the four registers.
    always_comb begin
        case (reg_addr)
            RA_CTRL: reg_rdata = {ack_en, pre_sel, ie, pend, div};
            RA_STAT: reg_rdata = {mode, busy, txen, lost_f, 2'b00, nack_f};
            RA_DATA: reg_rdata = data_q;
            default: reg_rdata = own_q;
        endcase
    end

    // R4
    hold_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && busy) |-> scl_drive_low);
    // R7
    bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (!scl_drive_low && !sda_drive_low));
    // R10
    irq_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && ie) |=> irq);
    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_start |=> busy);
endmodule

// File: tb/i2cm_byte_master_tb.sv
// Bench: small prescalers, a modelled slave on the bus, and arithmetic
// expectations for periods, bytes, acknowledges and flags.
module i2cm_byte_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int P_LO = 4;
    localparam int P_HI = 8;
    localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;

    logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0, reg_rdata;
    logic scl_drive_low, sda_drive_low, irq;
    logic s_low = 1'b0, force_low = 1'b0, slave_nack = 1'b0;
    wire  scl_w = !scl_drive_low;
    wire  sda_w = !(sda_drive_low || s_low || force_low);

    int checks = 0, errors = 0, cyc = 0;
    bit done = 1'b0;

    i2cm_byte_master #(.PRE_LO(P_LO), .PRE_HI(P_HI)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_drive_low(scl_drive_low),
        .sda_drive_low(sda_drive_low), .sda_in(sda_w), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = !clk;

    // Slave model state
    logic prev_scl = 1'b1, prev_sda = 1'b1;
    int bcnt = 0, starts = 0, stops = 0, wn = 0, mn = 0, rk = 0;
    int last_rise = 0, per = 0;
    bit just_st = 0, first = 0, rdm = 0, nackd = 0;
    logic [7:0] shreg = 8'd0, rdat = 8'd0;
    logic [7:0] wlog [64];
    logic       mack [64];

    function automatic logic [7:0] rbyte(input int k);
        return 8'hA5 ^ 8'(k * 37);
    endfunction

    // Modelled slave: decodes conditions, bytes and acknowledges on the bus.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (scl_w && prev_scl && prev_sda && !sda_w) begin
            starts++; bcnt = 0; first = 1; rdm = 0; just_st = 1; nackd = 0;
        end else if (scl_w && prev_scl && !prev_sda && sda_w) begin
            stops++;
        end else if (scl_w && !prev_scl) begin
            per = cyc - last_rise; last_rise = cyc;
            if (bcnt < 8) shreg = {shreg[6:0], sda_w};
            else if (!rdm || first) begin if (wn < 64) wlog[wn] = shreg; wn++; end
            else begin if (mn < 64) mack[mn] = sda_w; mn++; if (sda_w) nackd = 1; end
        end else if (!scl_w && prev_scl) begin
            if (just_st) begin just_st = 0; s_low = 0; end
            else if (bcnt == 8) begin
                bcnt = 0;
                if (first) begin
                    first = 0; rdm = shreg[0];
                    if (rdm) begin rk = 0; rdat = rbyte(0); end
                end else if (rdm) begin rk++; rdat = rbyte(rk); end
                s_low = (rdm && !nackd) ? !rdat[7] : 1'b0;
            end else begin
                bcnt++;
                if (bcnt == 8) s_low = (!rdm || first) ? !slave_nack : 1'b0;
                else s_low = (rdm && !first) ? !rdat[7 - bcnt] : 1'b0;
            end
        end
        prev_scl = scl_w; prev_sda = sda_w;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic wait_pend();
        logic [7:0] v;
        for (int i = 0; i < 5000; i++) begin rd(A_CTRL, v); if (v[4]) break; end
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        for (int i = 0; i < 5000; i++) begin rd(A_STAT, v); if (!v[5]) break; end
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        while (cyc < 190000 && !done) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, ctrlv, a;
        int st0, sp0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(A_CTRL, v); chk(v == 8'h00, "R1 ctrl", v, 0);
        rd(A_STAT, v); chk(v == 8'h00, "R1 stat", v, 0);
        rd(A_DATA, v); chk(v == 8'h00, "R1 data", v, 0);
        chk(!scl_drive_low && !sda_drive_low && !irq, "R1 lines",
            {scl_drive_low, sda_drive_low, irq}, 0);

        // R11 start refused while enable bit is 0
        wr(A_STAT, 8'hE0); repeat (60) @(negedge clk);
        rd(A_STAT, v); chk(!v[5], "R11 busy", v[5], 0);
        chk(starts == 0, "R11 no start", starts, 0);

        // R2 R3 R5 sweep over both prescalers and every divisor
        for (int ps = 0; ps < 2; ps++) begin
            for (int d = 0; d < 16; d++) begin
                ctrlv = {1'b1, 1'(ps), 2'b00, 4'(d)};
                wr(A_CTRL, ctrlv);
                a = 8'((d * 29 + ps * 101 + 6) & 8'hFE);
                st0 = starts; sp0 = stops;
                wr(A_DATA, a); wr(A_STAT, 8'hF0); wait_pend();
                chk(per == (ps ? P_HI : P_LO) * (d + 1), "R2 period", per,
                    (ps ? P_HI : P_LO) * (d + 1));
                chk(wlog[wn - 1] == a, "R3 address byte", wlog[wn - 1], a);
                rd(A_STAT, v);
                chk(v[5] && !v[0], "R5 busy and ack", v, 8'h20);
                chk(starts == st0 + 1, "R12 one start", starts, st0 + 1);
                wr(A_STAT, 8'hD0); wr(A_CTRL, ctrlv); wait_idle();
                chk(stops == sp0 + 1, "R7 stop seen", stops, sp0 + 1);
            end
        end

        // R4 R10 multi-byte write with hold and interrupt
        ctrlv = 8'hA1; wr(A_CTRL, ctrlv);
        st0 = starts; sp0 = stops;
        wr(A_DATA, 8'h3C); wr(A_STAT, 8'hF0); wait_pend();
        repeat (300) @(negedge clk);
        chk(scl_drive_low, "R4 scl held", scl_drive_low, 1);
        chk(irq, "R10 irq with enable", irq, 1);
        for (int k = 0; k < 3; k++) begin
            a = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'h5A;
            wr(A_DATA, a); wr(A_CTRL, ctrlv); wait_pend();
            chk(wlog[wn - 1] == a, "R4 data byte", wlog[wn - 1], a);
        end
        wr(A_CTRL, 8'h81);
        wr(A_DATA, 8'h77); wr(A_CTRL, 8'h81); wait_pend();
        chk(!irq, "R10 irq masked", irq, 0);
        wr(A_STAT, 8'hD0); wr(A_CTRL, 8'h81); wait_idle();
        chk(starts == st0 + 1 && stops == sp0 + 1, "R12 framing", stops - sp0, 1);

        // R5 refused acknowledge
        slave_nack = 1'b1;
        wr(A_DATA, 8'h44); wr(A_STAT, 8'hF0); wait_pend();
        rd(A_STAT, v); chk(v[0], "R5 nack flag", v[0], 1);
        slave_nack = 1'b0;
        wr(A_STAT, 8'hD0); wr(A_CTRL, 8'h81); wait_idle();

        // R6 R8 random-address read: write pointer, repeated start, read 3 bytes
        ctrlv = 8'hA1; wr(A_CTRL, ctrlv);
        st0 = starts; mn = 0;
        wr(A_DATA, 8'h50); wr(A_STAT, 8'hF0); wait_pend();
        wr(A_DATA, 8'h07); wr(A_CTRL, ctrlv); wait_pend();
        wr(A_STAT, 8'hB0); wr(A_DATA, 8'h51); wr(A_CTRL, ctrlv); wait_pend();
        chk(starts == st0 + 2, "R6 repeated start", starts, st0 + 2);
        chk(wlog[wn - 1] == 8'h51, "R6 read address", wlog[wn - 1], 8'h51);
        for (int k = 0; k < 3; k++) begin
            wr(A_CTRL, (k == 2) ? 8'h21 : ctrlv); wait_pend();
            rd(A_DATA, v); chk(v == rbyte(k), "R8 read byte", v, rbyte(k));
        end
        chk(mack[0] == 1'b0 && mack[1] == 1'b0, "R8 ack driven", {mack[0], mack[1]}, 0);
        chk(mack[2] == 1'b1, "R8 final nack", mack[2], 1);
        sp0 = stops;
        wr(A_STAT, 8'h90); wr(A_CTRL, 8'h21); wait_idle();
        chk(stops == sp0 + 1, "R7 stop after read", stops, sp0 + 1);

        // R9 SDA forced low while the controller releases it
        st0 = starts;
        wr(A_CTRL, 8'hA1);
        wr(A_DATA, 8'hC0); wr(A_STAT, 8'hF0);
        for (int i = 0; i < 2000 && starts == st0; i++) @(negedge clk);
        force_low = 1'b1;
        repeat (200) @(negedge clk);
        rd(A_STAT, v); chk(v[3] && !v[5], "R9 lost flag", v, 8'h08);
        rd(A_CTRL, v); chk(v[4], "R9 pending", v[4], 1);
        chk(!scl_drive_low && !sda_drive_low, "R9 released",
            {scl_drive_low, sda_drive_low}, 0);
        force_low = 1'b0;
        repeat (5) @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule